// File: doc/BRIEF.md
# Token-Network Controller Host Register Bank

This block is the byte-wide register file that a host microcontroller sees when it drives a token-passing network controller. It decodes a three-bit register address and holds the node status and diagnostic flags. It also holds the command port, a staged two-byte RAM pointer, the configuration byte, a sub-address selector and two setup bytes. The network engine raises events into the status and diagnostic registers through set and clear pulse inputs. The bank hands commands and pointer loads back to the rest of the controller as one-cycle strobes.

Address 7 is a window shared by several registers, and the sub-address bits steer it. The two low sub-address bits live in one copy that both the configuration and the sub-address registers show, so they always read the same. The bank has two reset classes. The hardware reset restores every register. A software reset, requested through the top bit of a configuration write, restores only the status and diagnostic registers and leaves the configuration and setup bytes as they were.

Register map (regAddr): 0 status read / command write, 1 diagnostic status (read only), 2 pointer high, 3 pointer low, 4 configuration, 5 sub-address, 6 unused, 7 shared window.

Top module: `netreg_bank`

## Requirements
- R1: After hardware reset the status register reads 1001_0001 with bits 6:5 replaced by statusLive. The diagnostic register reads 0000_000 followed by diagLive in bit 0. Configuration reads 0x18, sub-address reads 0, and both setup bytes are 0.
- R2: Status bits 6:5 always show statusLive. Bits 7 and 4:0 are set by statusSet and cleared by statusClr pulses, and a set wins over a clear in the same cycle. statusSet bits 6:5 have no effect.
- R3: A read of the diagnostic register (regAddr 1 with rdEn) clears flag bits 6:2 at that clock edge. A diagSet pulse in the same cycle wins over the clear.
- R4: Diagnostic bit 7 (excessive NAK) and bit 1 (new next ID) keep their value across reads.
- R5: A command write (regAddr 0) raises cmdValid for exactly the following cycle, with cmdByte equal to the written byte. Writing CLR_CMD (default 0x1E) also clears diagnostic bit 7. Other command values leave bit 7 unchanged.
- R6: A pointer-high write (regAddr 2) only stages its byte: there is no ptrLoad and ptrAddr is unchanged. A pointer-low write (regAddr 3) pulses ptrLoad for one cycle and loads ptrAddr = {high[2:0], low} for an 11-bit address.
- R7: A configuration write (regAddr 4) stores bits 6:0, copies bits 1:0 into sub-address bits 1:0 and clears sub-address bit 2. Configuration bit 7 always reads 0.
- R8: A sub-address write (regAddr 5) stores bits 2:0, which read back in bits 2:0 of register 5. Bits 1:0 also appear in configuration bits 1:0 and in cfgOut.
- R9: At regAddr 7, sub-address bit 2 set selects setup 2, and sub-address 000 selects setup 1. The other sub-address values read 0 and ignore writes.
- R10: Setup 1 bit 0 drives slowData (reduced 156.25 kbps rate), bit 1 drives halfArb, bit 2 drives rcvAll and bit 3 drives pulseDrv. setup2Out shows setup 2.
- R11: A configuration write with bit 7 set raises softRstPulse in the next cycle. At the edge that ends that cycle, status and diagnostic return to their R1 defaults. Configuration, sub-address, setup bytes and ptrAddr keep their values.
- R12: Reading regAddr 6 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hwRstN | input | 1 | Hardware reset, active low, synchronous |
| regAddr | input | 3 | Register address |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe (drives clear-on-read) |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for regAddr, combinational |
| statusLive | input | 2 | Live state shown in status bits 6:5 |
| statusSet | input | 8 | Status set pulses from engine |
| statusClr | input | 8 | Status clear pulses from engine |
| diagLive | input | 1 | Live state shown in diagnostic bit 0 |
| diagSet | input | 8 | Diagnostic set pulses from engine |
| cmdValid | output | 1 | One-cycle command strobe |
| cmdByte | output | 8 | Command byte |
| ptrLoad | output | 1 | One-cycle pointer load strobe |
| ptrAddr | output | 11 | Loaded RAM address |
| cfgOut | output | 8 | Configuration byte |
| slowData | output | 1 | Reduced data rate select |
| halfArb | output | 1 | Half-speed arbitration select |
| rcvAll | output | 1 | Receive-all mode |
| pulseDrv | output | 1 | Pulse driver type select |
| setup2Out | output | 8 | Setup 2 byte |
| softRstPulse | output | 1 | Software reset strobe |

## Verification
The bench sweeps every configuration byte below 0x80 after forcing sub-address bit 2 high. This separates a correct mirror-and-clear from a bank that keeps two independent copies or forgets bit 2. Every sub-address value is tried against the shared window with a distinct pattern, so a steering error shows up as a wrong byte or as a write landing in the wrong setup register. Each diagnostic and status bit is raised alone and read twice. This tells the clear-on-read bits apart from the two exempt ones, and pairing a set with a read or clear in the same cycle pins the priority. The 256 command bytes and the pointer high/low pairs show that only the clear command touches the excessive-NAK flag and that only the low write loads the address.

// File: rtl/netreg_pkg.sv
package netreg_pkg;
  localparam int DATA_W = 8;
  localparam int REG_ADDR_W = 3;

  typedef enum logic [REG_ADDR_W-1:0] {
    RA_STAT_CMD = 3'd0,
    RA_DIAG     = 3'd1,
    RA_PTR_HI   = 3'd2,
    RA_PTR_LO   = 3'd3,
    RA_CFG      = 3'd4,
    RA_SUBADR   = 3'd5,
    RA_SPARE    = 3'd6,
    RA_SHARED   = 3'd7
  } regAddrE;

  // status: latched bits and reset value; bits 6:5 come from live inputs
  localparam logic [DATA_W-1:0] STATUS_RST  = 8'h91;
  localparam logic [DATA_W-1:0] STATUS_KEEP = 8'h9F;
  localparam int STATUS_LIVE_LO = 5;

  // diagnostic: bit 0 live, bits 7 and 1 exempt from clear-on-read
  localparam logic [DATA_W-1:0] DIAG_RDCLR = 8'h7C;
  localparam int EXCNAK_BIT = 7;

  localparam logic [DATA_W-1:0] CFG_RST = 8'h18;
  localparam int CFG_SWRST_BIT = 7;

  typedef enum logic [1:0] {
    SEL_SETUP1 = 2'd0,
    SEL_SETUP2 = 2'd1,
    SEL_NONE   = 2'd2
  } sharedSelE;

  typedef struct packed {
    logic wrCmd;
    logic wrPtrHi;
    logic wrPtrLo;
    logic wrCfg;
    logic wrSub;
    logic wrSetup1;
    logic wrSetup2;
    logic rdDiag;
    logic clrExcNak;
    logic swReset;
  } strobeT;
endpackage

// File: rtl/netreg_ctrl.sv
module netreg_ctrl
  import netreg_pkg::*;
#(
  parameter logic [7:0] CLR_CMD = 8'h1E
) (
  input  logic                  clk,
  input  logic                  hwRstN,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic                  wrEn,
  input  logic                  rdEn,
  input  logic [DATA_W-1:0]     wrData,
  input  logic [2:0]            subAd,
  output strobeT                strb,
  output sharedSelE             sharedSel
);
  regAddrE addrE;
  logic    swRstPend;
  logic    wrAny;

  assign addrE = regAddrE'(regAddr);
  assign wrAny = wrEn;

  always_comb begin
    if (subAd[2])            sharedSel = SEL_SETUP2;
    else if (subAd[1:0] == 2'b00) sharedSel = SEL_SETUP1;
    else                     sharedSel = SEL_NONE;
  end

  always_comb begin
    strb           = '0;
    strb.wrCmd     = wrAny && (addrE == RA_STAT_CMD);
    strb.wrPtrHi   = wrAny && (addrE == RA_PTR_HI);
    strb.wrPtrLo   = wrAny && (addrE == RA_PTR_LO);
    strb.wrCfg     = wrAny && (addrE == RA_CFG);
    strb.wrSub     = wrAny && (addrE == RA_SUBADR);
    strb.wrSetup1  = wrAny && (addrE == RA_SHARED) && (sharedSel == SEL_SETUP1);
    strb.wrSetup2  = wrAny && (addrE == RA_SHARED) && (sharedSel == SEL_SETUP2);
    strb.rdDiag    = rdEn && (addrE == RA_DIAG);
    strb.clrExcNak = strb.wrCmd && (wrData == CLR_CMD);
    strb.swReset   = swRstPend;
  end

  always_ff @(posedge clk) begin
    if (!hwRstN) swRstPend <= 1'b0;
    else         swRstPend <= wrAny && (addrE == RA_CFG) && wrData[CFG_SWRST_BIT];
  end
endmodule

// File: rtl/netreg_dp.sv
module netreg_dp
  import netreg_pkg::*;
#(
  parameter int RAM_ADDR_W = 11
) (
  input  logic                  clk,
  input  logic                  hwRstN,
  input  strobeT                strb,
  input  sharedSelE             sharedSel,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0]     wrData,
  input  logic [1:0]            statusLive,
  input  logic [DATA_W-1:0]     statusSet,
  input  logic [DATA_W-1:0]     statusClr,
  input  logic                  diagLive,
  input  logic [DATA_W-1:0]     diagSet,
  output logic [DATA_W-1:0]     rdData,
  output logic                  cmdValid,
  output logic [DATA_W-1:0]     cmdByte,
  output logic                  ptrLoad,
  output logic [RAM_ADDR_W-1:0] ptrAddr,
  output logic [DATA_W-1:0]     cfgOut,
  output logic [DATA_W-1:0]     setup1Out,
  output logic [DATA_W-1:0]     setup2Out,
  output logic [DATA_W-1:0]     statusQ,
  output logic [DATA_W-1:0]     diagQ,
  output logic [2:0]            subAdQ
);
  localparam int HI_BITS = RAM_ADDR_W - DATA_W;

  logic [DATA_W-1:0] ptrHiQ, ptrLoQ;
  logic [6:2]        cfgHiQ;
  logic [DATA_W-1:0] setup1Q, setup2Q;
  logic [DATA_W-1:1] diagFlags;
  logic [DATA_W-1:0] diagSetM;
  logic [DATA_W-1:0] statusRd, diagRd, sharedRd;
  regAddrE           addrE;

  assign addrE    = regAddrE'(regAddr);
  assign diagSetM = diagSet & ~8'h01;

  // status register: reset on either class
  always_ff @(posedge clk) begin
    if (!hwRstN)           statusQ <= STATUS_RST;
    else if (strb.swReset) statusQ <= STATUS_RST;
    else                   statusQ <= ((statusQ & ~statusClr) | statusSet) & STATUS_KEEP;
  end

  // diagnostic flags, one flop per bit with its own clear class
  for (genvar i = 1; i < DATA_W; i++) begin : g_diag
    localparam bit RD_CLEARS = DIAG_RDCLR[i];
    localparam bit CMD_CLEARS = (i == EXCNAK_BIT);
    always_ff @(posedge clk) begin
      if (!hwRstN)                           diagFlags[i] <= 1'b0;
      else if (strb.swReset)                 diagFlags[i] <= 1'b0;
      else if (diagSetM[i])                  diagFlags[i] <= 1'b1;
      else if (CMD_CLEARS && strb.clrExcNak) diagFlags[i] <= 1'b0;
      else if (RD_CLEARS && strb.rdDiag)     diagFlags[i] <= 1'b0;
    end
  end
  assign diagQ = {diagFlags, 1'b0};

  // command strobe
  always_ff @(posedge clk) begin
    if (!hwRstN) begin
      cmdValid <= 1'b0;
      cmdByte  <= '0;
    end else begin
      cmdValid <= strb.wrCmd;
      if (strb.wrCmd) cmdByte <= wrData;
    end
  end

  // pointer staging and load
  always_ff @(posedge clk) begin
    if (!hwRstN) begin
      ptrHiQ  <= '0;
      ptrLoQ  <= '0;
      ptrAddr <= '0;
      ptrLoad <= 1'b0;
    end else begin
      ptrLoad <= strb.wrPtrLo;
      if (strb.wrPtrHi) ptrHiQ <= wrData;
      if (strb.wrPtrLo) begin
        ptrLoQ  <= wrData;
        ptrAddr <= {ptrHiQ[HI_BITS-1:0], wrData};
      end
    end
  end

  // configuration and the single shared copy of the sub-address bits
  always_ff @(posedge clk) begin
    if (!hwRstN) begin
      cfgHiQ <= CFG_RST[6:2];
      subAdQ <= {1'b0, CFG_RST[1:0]};
    end else if (strb.wrCfg) begin
      cfgHiQ <= wrData[6:2];
      subAdQ <= {1'b0, wrData[1:0]};
    end else if (strb.wrSub) begin
      subAdQ <= wrData[2:0];
    end
  end
  assign cfgOut = {1'b0, cfgHiQ, subAdQ[1:0]};

  // setup registers: hardware reset only
  always_ff @(posedge clk) begin
    if (!hwRstN) begin
      setup1Q <= '0;
      setup2Q <= '0;
    end else begin
      if (strb.wrSetup1) setup1Q <= wrData;
      if (strb.wrSetup2) setup2Q <= wrData;
    end
  end
  assign setup1Out = setup1Q;
  assign setup2Out = setup2Q;

  // read path
  always_comb begin
    statusRd = statusQ;
    statusRd[STATUS_LIVE_LO +: 2] = statusLive;
    diagRd = {diagQ[DATA_W-1:1], diagLive};
    case (sharedSel)
      SEL_SETUP1: sharedRd = setup1Q;
      SEL_SETUP2: sharedRd = setup2Q;
      default:    sharedRd = '0;
    endcase
  end

  always_comb begin
    case (addrE)
      RA_STAT_CMD: rdData = statusRd;
      RA_DIAG:     rdData = diagRd;
      RA_PTR_HI:   rdData = ptrHiQ;
      RA_PTR_LO:   rdData = ptrLoQ;
      RA_CFG:      rdData = cfgOut;
      RA_SUBADR:   rdData = {5'b0, subAdQ};
      RA_SHARED:   rdData = sharedRd;
      default:     rdData = '0;
    endcase
  end
endmodule

// File: rtl/netreg_bank.sv
module netreg_bank
  import netreg_pkg::*;
#(
  parameter int         RAM_ADDR_W = 11,
  parameter logic [7:0] CLR_CMD    = 8'h1E
) (
  input  logic                  clk,
  input  logic                  hwRstN,
  input  logic [2:0]            regAddr,
  input  logic                  wrEn,
  input  logic                  rdEn,
  input  logic [7:0]            wrData,
  output logic [7:0]            rdData,
  input  logic [1:0]            statusLive,
  input  logic [7:0]            statusSet,
  input  logic [7:0]            statusClr,
  input  logic                  diagLive,
  input  logic [7:0]            diagSet,
  output logic                  cmdValid,
  output logic [7:0]            cmdByte,
  output logic                  ptrLoad,
  output logic [RAM_ADDR_W-1:0] ptrAddr,
  output logic [7:0]            cfgOut,
  output logic                  slowData,
  output logic                  halfArb,
  output logic                  rcvAll,
  output logic                  pulseDrv,
  output logic [7:0]            setup2Out,
  output logic                  softRstPulse
);
  strobeT     strb;
  sharedSelE  sharedSel;
  logic [7:0] statusQ, diagQ, setup1Out;
  logic [2:0] subAdQ;

  netreg_ctrl #(.CLR_CMD(CLR_CMD)) u_ctrl (
    .clk(clk), .hwRstN(hwRstN), .regAddr(regAddr), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .subAd(subAdQ), .strb(strb), .sharedSel(sharedSel)
  );

  netreg_dp #(.RAM_ADDR_W(RAM_ADDR_W)) u_dp (
    .clk(clk), .hwRstN(hwRstN), .strb(strb), .sharedSel(sharedSel),
    .regAddr(regAddr), .wrData(wrData), .statusLive(statusLive),
    .statusSet(statusSet), .statusClr(statusClr), .diagLive(diagLive),
    .diagSet(diagSet), .rdData(rdData), .cmdValid(cmdValid), .cmdByte(cmdByte),
    .ptrLoad(ptrLoad), .ptrAddr(ptrAddr), .cfgOut(cfgOut), .setup1Out(setup1Out),
    .setup2Out(setup2Out), .statusQ(statusQ), .diagQ(diagQ), .subAdQ(subAdQ)
  );

  assign slowData     = setup1Out[0];
  assign halfArb      = setup1Out[1];
  assign rcvAll       = setup1Out[2];
  assign pulseDrv     = setup1Out[3];
  assign softRstPulse = strb.swReset;
endmodule

// File: rtl/netreg_bank_chk.sv
module netreg_bank_chk #(
  parameter int         RAM_ADDR_W = 11,
  parameter logic [7:0] CLR_CMD    = 8'h1E
) (
  input logic                  clk,
  input logic                  hwRstN,
  input logic [2:0]            regAddr,
  input logic                  wrEn,
  input logic                  rdEn,
  input logic [7:0]            wrData,
  input logic [7:0]            diagSet,
  input logic                  cmdValid,
  input logic [7:0]            cmdByte,
  input logic                  ptrLoad,
  input logic [RAM_ADDR_W-1:0] ptrAddr,
  input logic                  softRstPulse,
  input logic [7:0]            statusQ,
  input logic [7:0]            diagQ,
  input logic [2:0]            subAdQ
);
  logic diagRead, clrWrite;
  assign diagRead = rdEn && (regAddr == 3'd1);
  assign clrWrite = wrEn && (regAddr == 3'd0) && (wrData == CLR_CMD);

  assert_cmd_pulse_R5: assert property (@(posedge clk) disable iff (!hwRstN)
    (wrEn && regAddr == 3'd0) |=> (cmdValid && cmdByte == $past(wrData)));
  assert_cmd_quiet_R5: assert property (@(posedge clk) disable iff (!hwRstN)
    !(wrEn && regAddr == 3'd0) |=> !cmdValid);
  assert_ptr_hold_R6: assert property (@(posedge clk) disable iff (!hwRstN)
    !ptrLoad |-> $stable(ptrAddr));
  assert_ptr_load_R6: assert property (@(posedge clk) disable iff (!hwRstN)
    (wrEn && regAddr == 3'd3) |=> (ptrLoad && ptrAddr[7:0] == $past(wrData)));
  assert_rd_clear_R3: assert property (@(posedge clk) disable iff (!hwRstN)
    (diagRead && diagSet == 8'h00) |=> (diagQ[6:2] == 5'b0));
  assert_exempt_keep_R4: assert property (@(posedge clk) disable iff (!hwRstN)
    (diagRead && diagSet == 8'h00 && !softRstPulse && !clrWrite)
      |=> (diagQ[7] == $past(diagQ[7]) && diagQ[1] == $past(diagQ[1])));
  assert_cfg_sub_R7: assert property (@(posedge clk) disable iff (!hwRstN)
    (wrEn && regAddr == 3'd4) |=> (subAdQ == {1'b0, $past(wrData[1:0])}));
  assert_soft_reset_R11: assert property (@(posedge clk) disable iff (!hwRstN)
    softRstPulse |=> (statusQ == 8'h91 && diagQ == 8'h00));
  assert_soft_req_R11: assert property (@(posedge clk) disable iff (!hwRstN)
    (wrEn && regAddr == 3'd4 && wrData[7]) |=> softRstPulse);
endmodule

bind netreg_bank netreg_bank_chk #(.RAM_ADDR_W(RAM_ADDR_W), .CLR_CMD(CLR_CMD)) u_chk (
  .clk(clk), .hwRstN(hwRstN), .regAddr(regAddr), .wrEn(wrEn), .rdEn(rdEn),
  .wrData(wrData), .diagSet(diagSet), .cmdValid(cmdValid), .cmdByte(cmdByte),
  .ptrLoad(ptrLoad), .ptrAddr(ptrAddr), .softRstPulse(softRstPulse),
  .statusQ(statusQ), .diagQ(diagQ), .subAdQ(subAdQ)
);

// File: tb/netreg_bank_bench.sv
module netreg_bank_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] CLR = 8'h1E;

  logic        clk = 1'b0;
  logic        hwRstN = 1'b0;
  logic [2:0]  regAddr = '0;
  logic        wrEn = 1'b0, rdEn = 1'b0;
  logic [7:0]  wrData = '0;
  logic [7:0]  rdData;
  logic [1:0]  statusLive = 2'b10;
  logic [7:0]  statusSet = '0, statusClr = '0, diagSet = '0;
  logic        diagLive = 1'b1;
  logic        cmdValid, ptrLoad, slowData, halfArb, rcvAll, pulseDrv, softRstPulse;
  logic [7:0]  cmdByte, cfgOut, setup2Out;
  logic [10:0] ptrAddr;

  int total = 0, bad = 0;
  logic [7:0] got;

  netreg_bank u_netreg_bank (
    .clk(clk), .hwRstN(hwRstN), .regAddr(regAddr), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData), .statusLive(statusLive), .statusSet(statusSet),
    .statusClr(statusClr), .diagLive(diagLive), .diagSet(diagSet),
    .cmdValid(cmdValid), .cmdByte(cmdByte), .ptrLoad(ptrLoad), .ptrAddr(ptrAddr),
    .cfgOut(cfgOut), .slowData(slowData), .halfArb(halfArb), .rcvAll(rcvAll),
    .pulseDrv(pulseDrv), .setup2Out(setup2Out), .softRstPulse(softRstPulse)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; wrData = d; wrEn = 1'b1;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a; rdEn = 1'b1;
    #(CLK_PERIOD/4);
    d = rdData;
    @(posedge clk); #1;
    rdEn = 1'b0;
  endtask

  task automatic pulseStat(input logic [7:0] s, input logic [7:0] c);
    @(negedge clk);
    statusSet = s; statusClr = c;
    @(posedge clk); #1;
    statusSet = '0; statusClr = '0;
  endtask

  task automatic pulseDiag(input logic [7:0] s);
    @(negedge clk);
    diagSet = s;
    @(posedge clk); #1;
    diagSet = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] cfgM, s1M, s2M, pat, liveBits;
    logic [10:0] ptrM;
    repeat (3) @(posedge clk);
    @(negedge clk); hwRstN = 1'b1;

    // R1 reset defaults
    rd(3'd0, got); check("R1 status", got, 8'hD1);
    rd(3'd1, got); check("R1 diag", got, 8'h01);
    rd(3'd4, got); check("R1 config", got, 8'h18);
    rd(3'd5, got); check("R1 subaddr", got, 8'h00);
    rd(3'd7, got); check("R1 setup1", got, 8'h00);
    check("R1 setup2", setup2Out, 0);
    check("R1 cmdValid", cmdValid, 0);

    // R2 live bits and latched set/clear
    for (int l = 0; l < 4; l++) begin
      statusLive = 2'(l);
      rd(3'd0, got); check("R2 live", got, 8'h91 | (l << 5));
    end
    statusLive = 2'b10; liveBits = 8'h40;
    pulseStat(8'h00, 8'hFF);
    rd(3'd0, got); check("R2 cleared", got, liveBits);
    for (int i = 0; i < 8; i++) begin
      pulseStat(8'(1 << i), 8'h00);
      rd(3'd0, got);
      check("R2 set", got, ((i == 5 || i == 6) ? 0 : (1 << i)) | liveBits);
      pulseStat(8'(1 << i), 8'(1 << i));
      rd(3'd0, got);
      check("R2 set wins", got, ((i == 5 || i == 6) ? 0 : (1 << i)) | liveBits);
      pulseStat(8'h00, 8'(1 << i));
      rd(3'd0, got); check("R2 clear", got, liveBits);
    end

    // R3 R4 diagnostic clear-on-read classes
    for (int i = 1; i < 8; i++) begin
      pulseDiag(8'(1 << i));
      rd(3'd1, got); check("R3 diag set", got & 8'(1 << i), 1 << i);
      rd(3'd1, got);
      if (i == 7 || i == 1) check("R4 exempt kept", got & 8'(1 << i), 1 << i);
      else                  check("R3 read cleared", got & 8'(1 << i), 0);
    end
    rd(3'd1, got); check("R4 exempt pair", got, 8'h83);
    @(negedge clk);
    regAddr = 3'd1; rdEn = 1'b1; diagSet = 8'h08;
    @(posedge clk); #1;
    rdEn = 1'b0; diagSet = '0;
    rd(3'd1, got); check("R3 set beats read", got, 8'h8B);
    rd(3'd1, got); check("R3 cleared after", got, 8'h83);

    // R5 command sweep
    for (int v = 0; v < 256; v++) begin
      if (v == CLR) continue;
      wr(3'd0, 8'(v));
      check("R5 cmdValid", cmdValid, 1);
      check("R5 cmdByte", cmdByte, v);
      @(posedge clk); #1;
      check("R5 one cycle", cmdValid, 0);
    end
    rd(3'd1, got); check("R5 excnak kept", got, 8'h83);
    wr(3'd0, CLR);
    check("R5 clr cmdValid", cmdValid, 1);
    rd(3'd1, got); check("R5 excnak cleared", got, 8'h03);

    // R6 pointer staging
    ptrM = ptrAddr;
    for (int h = 0; h < 8; h++) begin
      for (int k = 0; k < 4; k++) begin
        pat = (k == 0) ? 8'h00 : (k == 1) ? 8'h5A : (k == 2) ? 8'hFF : 8'(h * 37 + 11);
        wr(3'd2, {5'b10101, 3'(h)});
        check("R6 hi no load", ptrLoad, 0);
        check("R6 hi addr hold", ptrAddr, ptrM);
        rd(3'd2, got); check("R6 hi readback", got, {5'b10101, 3'(h)});
        wr(3'd3, pat);
        ptrM = {3'(h), pat};
        check("R6 lo load", ptrLoad, 1);
        check("R6 addr", ptrAddr, ptrM);
        @(posedge clk); #1;
        check("R6 load one cycle", ptrLoad, 0);
      end
    end

    // R7 configuration mirrors and clears sub-address bit 2
    for (int v = 0; v < 128; v++) begin
      wr(3'd5, 8'h04);
      wr(3'd4, 8'(v));
      rd(3'd4, got); check("R7 cfg readback", got, v);
      check("R7 cfgOut", cfgOut, v);
      rd(3'd5, got); check("R7 sub mirror", got, v & 3);
    end
    cfgM = 8'h7F;

    // R8 sub-address writes update configuration copy
    for (int s = 0; s < 8; s++) begin
      wr(3'd5, 8'hF8 | 8'(s));
      rd(3'd5, got); check("R8 sub readback", got, s);
      rd(3'd4, got); check("R8 cfg mirror", got, (cfgM & 8'hFC) | (s & 3));
    end

    // R9 R10 shared window steering
    s1M = 8'h00; s2M = 8'h00;
    for (int s = 0; s < 8; s++) begin
      wr(3'd5, 8'(s));
      pat = 8'(8'h13 * (s + 1)) ^ 8'hA0;
      wr(3'd7, pat);
      if (s >= 4) s2M = pat;
      else if (s == 0) s1M = pat;
      rd(3'd7, got);
      check("R9 window", got, (s >= 4) ? s2M : (s == 0) ? s1M : 0);
      check("R9 setup2", setup2Out, s2M);
      check("R10 slowData", slowData, s1M[0]);
      check("R10 halfArb", halfArb, s1M[1]);
      check("R10 rcvAll", rcvAll, s1M[2]);
      check("R10 pulseDrv", pulseDrv, s1M[3]);
    end
    wr(3'd5, 8'h00);
    wr(3'd7, 8'h0A);
    s1M = 8'h0A;
    check("R10 fields", {pulseDrv, rcvAll, halfArb, slowData}, 4'hA);

    // R12 unused address
    rd(3'd6, got); check("R12 unused", got, 0);

    // R11 software reset
    wr(3'd5, 8'h04);
    wr(3'd7, 8'h3C);
    s2M = 8'h3C;
    pulseStat(8'h0E, 8'h00);
    pulseDiag(8'hFE);
    check("R11 no early pulse", softRstPulse, 0);
    wr(3'd4, 8'hD5);
    check("R11 pulse", softRstPulse, 1);
    @(posedge clk); #1;
    check("R11 pulse ends", softRstPulse, 0);
    rd(3'd0, got); check("R11 status", got, 8'hD1);
    rd(3'd1, got); check("R11 diag", got, 8'h01);
    rd(3'd4, got); check("R11 config kept", got, 8'h55);
    rd(3'd5, got); check("R11 sub kept", got, 8'h01);
    check("R11 setup1 kept", {pulseDrv, rcvAll, halfArb, slowData}, s1M[3:0]);
    check("R11 setup2 kept", setup2Out, s2M);
    check("R11 ptr kept", ptrAddr, ptrM);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule